// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a register-mapped timer peripheral holding a parameterized number of independent 32-bit down-counters. Each channel has its own control word, an interval (reload) word and a read-only view of the live count. Two shared words cover all channels: an interrupt-enable mask and a pending-expiry status word whose bits are cleared by writing 1. Software reaches everything through a plain single-cycle port: a word address, a write strobe, write data and a combinational read-data bus.

Time does not come from `clk` directly. The block receives a small set of tick-enable inputs, all sampled in the `clk` domain. Each channel picks one of them with a 2-bit select field and divides it by a power of two, from 1 to 128. A channel either repeats, reloading its interval whenever it expires, or fires once and stops. Disabling a running channel takes effect only after two further ticks of its selected source. Software that stops and then restarts a channel must allow for this delay. If the interval is all ones and the channel runs with reload, it is a full-range free-running counter. Inverting its value gives a rising timestamp.

Top module: `dtimer_bank`

## Requirements
- R1: Word addresses: 0 is the interrupt-enable mask and 1 is the status word. Channel n uses word 4n+4 for control, 4n+5 for interval and 4n+6 for current count. Any other address reads zero and ignores writes. The count word is read-only.
- R2: Control bits: bit 0 enables the channel, [3:2] select the tick source, [6:4] hold the prescale exponent and bit 7 selects one-shot. Bit 1 is a reload request. Writing 1 to it copies the interval into the count in the write cycle. Bit 1 always reads 0.
- R3: A running channel drops its count by exactly one on each prescaled tick. A stopped channel holds its count. Writing the interval word alone never changes the count.
- R4: In periodic mode (bit 7 = 0), a prescaled tick that finds the count at zero reloads the interval and sets the channel's status bit. The period is therefore interval+1 prescaled ticks.
- R5: In one-shot mode (bit 7 = 1), a prescaled tick that finds the count at zero sets the status bit, clears the enable bit and stops the channel. The count stays at zero.
- R6: With prescale exponent p, the count moves once every 2^p ticks of the selected source. The first move comes on the 2^p-th tick after the channel starts.
- R7: Only the tick input chosen by bits [3:2] advances a channel. Ticks on the other inputs have no effect.
- R8: Status bit n is set on channel n's expiry whatever the enable mask holds. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly when some channel has both its status bit and its enable-mask bit set.
- R10: When the enable bit of a running channel is cleared, the channel goes on counting through two more ticks of its selected source and then freezes.
- R11: After reset every register and count is zero and `irq_o` is low.
- R12: With interval all ones and a control write of enable plus reload, the count starts at 0xFFFFFFFF and then decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick_i | input | 4 | Tick-enable pulses, one per selectable source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | OR over channels of status AND enable |

## Verification
A fault in a channel's run or drain state shows up in the count word. If a channel stops too early or too late after disable, the count freezes at the wrong value, and that is visible one source tick after the error. A prescaler that is out of phase shifts the first decrement by at least one source tick. A lost or spurious expiry appears in the status word and on `irq_o` in the cycle after the tick that should have caused it. The same tick also shows a wrong reload or a missing stop in the count. Because ticks are driven one at a time and the count is read back after each group, every one of these faults appears within a few ticks of its cause.

// File: rtl/dtimer_pkg.sv
// Shared constants and types for the down-counting timer bank.
// Assumes a 2-bit tick-source select and a 3-bit prescale exponent.
package dtimer_pkg;
    localparam int SRC_SEL_W = 2;
    localparam int NUM_SRC   = 1 << SRC_SEL_W;
    localparam int PRE_W     = 3;
    localparam int CTL_W     = 8;

    // Word layout: shared words first, then four-word blocks per channel.
    localparam int WORD_IE  = 0;
    localparam int WORD_ST  = 1;
    localparam int BLK_WORDS = 4;
    localparam int OFS_CTRL = 0;
    localparam int OFS_INTV = 1;
    localparam int OFS_CNT  = 2;

    typedef struct packed {
        logic                 oneshot;
        logic [PRE_W-1:0]     pre;
        logic [SRC_SEL_W-1:0] src;
        logic                 en;
    } chan_ctrl_t;

    // Readback image of a control word; the reload request reads as 0.
    function automatic logic [CTL_W-1:0] ctrl_image(chan_ctrl_t c);
        return {c.oneshot, c.pre, c.src, 1'b0, c.en};
    endfunction
endpackage

// File: rtl/dtimer_prescale.sv
// Power-of-two tick divider for one channel.
// Emits a divided tick on every 2^pre_i-th source tick while run_i is high;
// the phase counter restarts whenever the channel is stopped.
module dtimer_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             ptick_o
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // Low bits of the phase that must all be ones for a divided tick.
    always_comb mask = ~({DIV_W{1'b1}} << pre_i);

    assign ptick_o = run_i && tick_i && ((phase_q & mask) == mask);

    // Phase counter advances on source ticks while running.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (!run_i) phase_q <= '0;
        else if (tick_i) phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/dtimer_channel.sv
// One down-counting timer channel: control, interval and count registers,
// periodic / one-shot expiry and the delayed stop after disable.
// Assumes write strobes are already decoded for this channel.
module dtimer_channel import dtimer_pkg::*; #(
    parameter int CNT_W       = 32,
    parameter int DRAIN_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic               ctrl_we_i,
    input  logic               intv_we_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic [CTL_W-1:0]   ctrl_o,
    output logic [CNT_W-1:0]   intv_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               expire_o
);
    localparam int DRN_W = $clog2(DRAIN_TICKS + 1);

    chan_ctrl_t       ctrl_q;
    logic [CNT_W-1:0] intv_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DRN_W-1:0] drain_q;
    logic             sel_tick;
    logic             ptick;

    assign sel_tick = src_tick_i[ctrl_q.src];

    dtimer_prescale #(.PRE_W(PRE_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_q),
        .tick_i  (sel_tick),
        .pre_i   (ctrl_q.pre),
        .ptick_o (ptick)
    );

    assign expire_o = run_q && ptick && (cnt_q == '0);
    assign ctrl_o   = ctrl_image(ctrl_q);
    assign intv_o   = intv_q;
    assign count_o  = cnt_q;

    // Counting, stop latency and register writes; later statements win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            intv_q  <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            drain_q <= '0;
        end else begin
            if (drain_q != '0 && sel_tick) begin
                drain_q <= drain_q - 1'b1;
                if (drain_q == DRN_W'(1)) run_q <= 1'b0;
            end
            if (run_q && ptick) begin
                if (cnt_q == '0) begin
                    if (ctrl_q.oneshot) begin
                        run_q     <= 1'b0;
                        ctrl_q.en <= 1'b0;
                        drain_q   <= '0;
                    end else begin
                        cnt_q <= intv_q;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (intv_we_i) intv_q <= wdata_i;
            if (ctrl_we_i) begin
                ctrl_q <= '{oneshot: wdata_i[7], pre: wdata_i[6:4],
                            src: wdata_i[3:2], en: wdata_i[0]};
                if (wdata_i[0]) begin
                    run_q   <= 1'b1;
                    drain_q <= '0;
                end else if (ctrl_q.en && run_q) begin
                    drain_q <= DRN_W'(DRAIN_TICKS);
                end
                if (wdata_i[1]) cnt_q <= intv_q;
            end
        end
    end

    // R10
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && !wdata_i[0] && ctrl_q.en && run_q) |=> run_q);

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && ctrl_q.oneshot && !ctrl_we_i)
        |=> (!run_q && cnt_q == '0 && !ctrl_q.en));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !(ctrl_we_i && wdata_i[1])) |=> (cnt_q == $past(cnt_q)));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !ctrl_q.oneshot && !ctrl_we_i && !intv_we_i)
        |=> (cnt_q == intv_q));
endmodule

// File: rtl/dtimer_bank.sv
// Register-mapped bank of down-counting timer channels with a shared
// interrupt-enable mask and write-one-to-clear status word.
// Assumes NUM_CH <= 32 and ADDR_W wide enough for 4*NUM_CH+3.
module dtimer_bank import dtimer_pkg::*; #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic [CNT_W-1:0]   rdata_o,
    output logic               irq_o
);
    logic [NUM_CH-1:0] ie_q;
    logic [NUM_CH-1:0] st_q;
    logic [NUM_CH-1:0] expire;
    logic [CTL_W-1:0]  ctrl_rd  [NUM_CH];
    logic [CNT_W-1:0]  intv_rd  [NUM_CH];
    logic [CNT_W-1:0]  count_rd [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int BASE = BLK_WORDS * (g + 1);
        logic ctrl_we;
        logic intv_we;

        assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(BASE + OFS_CTRL));
        assign intv_we = wr_en_i && (addr_i == ADDR_W'(BASE + OFS_INTV));

        dtimer_channel #(.CNT_W(CNT_W)) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_tick_i (src_tick_i),
            .ctrl_we_i  (ctrl_we),
            .intv_we_i  (intv_we),
            .wdata_i    (wdata_i),
            .ctrl_o     (ctrl_rd[g]),
            .intv_o     (intv_rd[g]),
            .count_o    (count_rd[g]),
            .expire_o   (expire[g])
        );

        // R8
        status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> st_q[g]);
    end

    // Shared enable mask and sticky status with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
            st_q <= '0;
        end else begin
            if (wr_en_i && addr_i == ADDR_W'(WORD_IE)) ie_q <= wdata_i[NUM_CH-1:0];
            if (wr_en_i && addr_i == ADDR_W'(WORD_ST))
                st_q <= (st_q & ~wdata_i[NUM_CH-1:0]) | expire;
            else
                st_q <= st_q | expire;
        end
    end

    assign irq_o = |(st_q & ie_q);

    // Combinational read mux; unmapped words return zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(WORD_IE)) rdata_o = CNT_W'(ie_q);
        if (addr_i == ADDR_W'(WORD_ST)) rdata_o = CNT_W'(st_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_i == ADDR_W'(BLK_WORDS * (i + 1) + OFS_CTRL)) rdata_o = CNT_W'(ctrl_rd[i]);
            if (addr_i == ADDR_W'(BLK_WORDS * (i + 1) + OFS_INTV)) rdata_o = intv_rd[i];
            if (addr_i == ADDR_W'(BLK_WORDS * (i + 1) + OFS_CNT))  rdata_o = count_rd[i];
        end
    end

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == '0) |-> !irq_o);
endmodule

// File: tb/test_dtimer_bank.sv
// Directed bench for dtimer_bank: one task per scenario, each self-checking.
module test_dtimer_bank;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dtimer_bank #(.NUM_CH(2), .CNT_W(32), .ADDR_W(AW)) i_dtimer_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick_i (src_tick),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(logic [AW-1:0] a, logic [31:0] d, int s);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; src_tick[s] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; src_tick = '0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic tick(int s, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_tick[s] = 1'b1;
            @(negedge clk);
            src_tick = '0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v);  check("R11 ie", v, 0);
        rd(1, v);  check("R11 st", v, 0);
        rd(4, v);  check("R11 ctrl0", v, 0);
        rd(6, v);  check("R11 cnt0", v, 0);
        check("R11 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(5, 100);
        wr(9, 55);
        rd(5, v);  check("R1 intv0", v, 100);
        rd(9, v);  check("R1 intv1", v, 55);
        wr(2, 32'hDEAD);
        rd(2, v);  check("R1 unused", v, 0);
        wr(6, 123);
        rd(6, v);  check("R1 count read-only", v, 0);
        wr(4, 32'hA6);
        rd(4, v);  check("R2 ctrl readback", v, 32'hA4);
        rd(6, v);  check("R2 reload copy", v, 100);
        wr(4, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(5, 3);
        wr(4, 32'h03);
        rd(6, v);  check("R3 start", v, 3);
        tick(0, 1);
        rd(6, v);  check("R3 decrement", v, 2);
        tick(1, 2);
        rd(6, v);  check("R7 other source ignored", v, 2);
        tick(0, 3);
        rd(6, v);  check("R4 reload", v, 3);
        rd(1, v);  check("R8 set while masked", v, 1);
        check("R9 irq masked", {31'b0, irq}, 0);
        wr(0, 1);
        @(negedge clk);
        check("R9 irq raised", {31'b0, irq}, 1);
        wr(1, 0);
        rd(1, v);  check("R8 write zero", v, 1);
        wr(1, 1);
        rd(1, v);  check("R8 clear", v, 0);
        check("R9 irq dropped", {31'b0, irq}, 0);
        wr(5, 10);
        rd(6, v);  check("R3 interval write", v, 3);
        wr(4, 0);
        tick(0, 5);
        rd(6, v);  check("R10 stop latency", v, 1);
        rd(4, v);  check("R10 ctrl cleared", v, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(9, 2);
        wr(8, 32'h83);
        rd(10, v); check("R5 start", v, 2);
        tick(0, 3);
        rd(10, v); check("R5 at zero", v, 0);
        rd(1, v);  check("R5 status", v, 2);
        rd(8, v);  check("R5 enable cleared", v, 32'h80);
        tick(0, 2);
        rd(10, v); check("R5 stays stopped", v, 0);
        check("R9 other mask", {31'b0, irq}, 0);
        wr(0, 3);
        @(negedge clk);
        check("R9 ch1 irq", {31'b0, irq}, 1);
        wr(1, 2);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(5, 20);
        wr(4, 32'h23);
        tick(0, 3);
        rd(6, v);  check("R6 before 4th", v, 20);
        tick(0, 1);
        rd(6, v);  check("R6 4th tick", v, 19);
        tick(0, 4);
        rd(6, v);  check("R6 8th tick", v, 18);
        wr(4, 32'h20);
        tick(0, 6);
        rd(6, v);  check("R10 prescaled drain", v, 18);
    endtask

    task automatic t_source();
        logic [31:0] v;
        wr(9, 5);
        wr(8, 32'h0B);
        tick(0, 3);
        rd(10, v); check("R7 unselected", v, 5);
        tick(2, 2);
        rd(10, v); check("R7 selected", v, 3);
        wr(8, 32'h08);
        tick(2, 3);
        rd(10, v); check("R10 ch1 drain", v, 1);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        wr(5, 0);
        wr(4, 32'h03);
        tick(0, 1);
        rd(1, v);  check("R4 zero interval expiry", v, 1);
        wr_tick(1, 1, 0);
        rd(1, v);  check("R8 set beats clear", v, 1);
        wr(4, 0);
        wr(1, 1);
        rd(1, v);  check("R8 clear after stop", v, 0);
    endtask

    task automatic t_freerun();
        logic [31:0] v;
        wr(5, 32'hFFFF_FFFF);
        wr(4, 32'h03);
        rd(6, v);  check("R12 full range", v, 32'hFFFF_FFFF);
        tick(0, 1);
        rd(6, v);  check("R12 decrement", v, 32'hFFFF_FFFE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_periodic();
        t_oneshot();
        t_prescale();
        t_source();
        t_setwins();
        t_freerun();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule